// File: doc/BRIEF.md
# Cascaded Two-Stage Watchdog Timer

This block is a software watchdog made of two chained down-counters, a low stage and a high stage. Each stage is `CNT_W` bits wide. Software reaches it through one control register that it can read and write. The watchdog stays dormant after reset. The first write of any value to the register arms it, and every later write kicks it. A kick reloads both stages to all-ones.

The low stage counts a clock-enable `tick`, which stands for the oscillator divided by 16. The high stage counts one of two sources, chosen by a control bit:

- the low stage's wrap-arounds, which gives a long timeout, or
- the `tick` itself, which gives a short timeout.

When the high stage wraps, the block emits a one-cycle `wd_reset` pulse. The pulse also puts the block back into its dormant state.

A second control bit can be set but not cleared by software. While it is set, a stop request from the processor becomes a watchdog reset instead of a halt. A register read returns both control bits and the upper bits of the live high counter.

Top module: `wdog_cascade`

## Requirements
- R1: From reset until the first register write, the counters do not move and `wd_reset` stays 0, whatever `tick` does.
- R2: Reset and every register write load both stages with all-ones. Right after a write, `rd_data[5:0]` reads 0x3F.
- R3: When the high stage is at 0 and receives a count event, `wd_reset` is 1 for exactly one cycle, in the cycle after that clock edge. In that same cycle the block is dormant and reads 0x3F: both counters are all-ones and both control bits are 0.
- R4: With `wr_data[7]`=0 written, the low stage decrements on each `tick` and reloads all-ones after 0. The high stage decrements once per low-stage wrap. The reset follows the 65536th `tick` after the write.
- R5: With `wr_data[7]`=1 written, the high stage decrements on every `tick`. The reset follows the 256th `tick` after the write.
- R6: Bit 6 (stop-lock) becomes the old value OR `wr_data[6]`. Writing 0 never clears it, and only a reset does. Bit 7 (source select) takes the written value.
- R7: If `stop_req` is 1 while the block is armed and bit 6 is 1, `halt_out` stays 0 and `wd_reset` pulses in the next cycle.
- R8: If `stop_req` is 1 while the block is dormant, or while bit 6 is 0, `halt_out` equals `stop_req` in the same cycle and no reset follows.
- R9: `rd_data` is laid out as follows: bit 7 is the source select, bit 6 is the stop-lock, and bits 5..0 are high-stage bits 7..2.
- R10: A write in the same cycle as a `tick` takes precedence, so both stages end at all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable (divided clock) |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | CNT_W | Control register write value |
| stop_req | input | 1 | Stop-instruction request from CPU |
| rd_data | output | CNT_W | Control register read value |
| halt_out | output | 1 | Permitted stop, forwarded to clock control |
| wd_reset | output | 1 | One-cycle internal reset pulse |

## Verification
The bench builds the block with the default `CNT_W` of 8 and drives `tick` on every cycle during long runs. This keeps the full 65536-tick cascaded timeout inside the run. Both exact timeout edges are therefore checked: the last tick that still reads 0x00 or 0x80, and the tick that fires. Using the real width also makes the readback of the high counter's upper six bits match the register format exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control and sequencing state shared by the control unit.
    typedef struct packed {
        logic run;    // armed by the first write
        logic src;    // high stage counts tick directly when 1
        logic lock;   // stop request turns into a reset when 1
        logic pulse;  // registered internal reset
    } wd_ctrl_t;

    // Field positions inside the control register, derived from its width.
    function automatic int src_pos(input int w);
        return w - 1;
    endfunction

    function automatic int lock_pos(input int w);
        return w - 2;
    endfunction

endpackage

// File: rtl/wdog_stage.sv
module wdog_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         evt,
    output logic [W-1:0] cnt,
    output logic         uf
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf   = evt && (st_q.cnt == '0);
        if (reload) begin
            st_d.cnt = ALL1;
        end else if (evt) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = ALL1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= ALL1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_src,
    input  logic wr_lock,
    input  logic hi_uf,
    input  logic stop_req,
    output logic run,
    output logic src,
    output logic lock,
    output logic fire,
    output logic pulse,
    output logic halt
);

    wd_ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        fire      = c_q.run && (hi_uf || (stop_req && c_q.lock));
        halt      = stop_req && !(c_q.run && c_q.lock);
        if (fire) begin
            c_d.run   = 1'b0;
            c_d.src   = 1'b0;
            c_d.lock  = 1'b0;
            c_d.pulse = 1'b1;
        end else if (wr_en) begin
            c_d.run  = 1'b1;
            c_d.src  = wr_src;
            c_d.lock = c_q.lock | wr_lock;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run   = c_q.run;
    assign src   = c_q.src;
    assign lock  = c_q.lock;
    assign pulse = c_q.pulse;

endmodule

// File: rtl/wdog_rdfmt.sv
module wdog_rdfmt #(
    parameter int W = 8
) (
    input  logic         src,
    input  logic         lock,
    input  logic [W-1:0] hi_cnt,
    output logic [W-1:0] rd
);

    localparam int DROP = 2;

    always_comb begin
        rd = {src, lock, hi_cnt[W-1:DROP]};
    end

endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stop_req,
    output logic [CNT_W-1:0] rd_data,
    output logic             halt_out,
    output logic             wd_reset
);

    localparam int SRC_BIT  = src_pos(CNT_W);
    localparam int LOCK_BIT = lock_pos(CNT_W);

    logic             run_w, src_w, lock_w, fire_w;
    logic             reload_w;
    logic             lo_evt, hi_evt, lo_uf, hi_uf;
    logic [CNT_W-1:0] lo_cnt, hi_cnt;

    assign reload_w = wr_en | fire_w;
    assign lo_evt   = run_w & tick;
    assign hi_evt   = src_w ? lo_evt : lo_uf;

    wdog_stage #(.W(CNT_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload_w),
        .evt    (lo_evt),
        .cnt    (lo_cnt),
        .uf     (lo_uf)
    );

    wdog_stage #(.W(CNT_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload_w),
        .evt    (hi_evt),
        .cnt    (hi_cnt),
        .uf     (hi_uf)
    );

    wdog_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_src   (wr_data[SRC_BIT]),
        .wr_lock  (wr_data[LOCK_BIT]),
        .hi_uf    (hi_uf),
        .stop_req (stop_req),
        .run      (run_w),
        .src      (src_w),
        .lock     (lock_w),
        .fire     (fire_w),
        .pulse    (wd_reset),
        .halt     (halt_out)
    );

    wdog_rdfmt #(.W(CNT_W)) u_rd (
        .src    (src_w),
        .lock   (lock_w),
        .hi_cnt (hi_cnt),
        .rd     (rd_data)
    );

endmodule

// File: rtl/wdog_cascade_chk.sv
module wdog_cascade_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             stop_req,
    input logic             wd_reset,
    input logic             halt_out,
    input logic [CNT_W-1:0] rd_data,
    input logic             run,
    input logic             lock,
    input logic             fire,
    input logic             hi_uf,
    input logic [CNT_W-1:0] lo_cnt,
    input logic [CNT_W-1:0] hi_cnt
);

    localparam logic [CNT_W-1:0] IDLE_RD = {2'b00, {(CNT_W-2){1'b1}}};

    p_dormant_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> (lo_cnt == '1 && hi_cnt == '1 && !wd_reset));

    p_write_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fire) |=> (lo_cnt == '1 && hi_cnt == '1 && run));

    p_underflow_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_uf |=> wd_reset);

    p_pulse_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |-> (!run && rd_data == IDLE_RD));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |=> !wd_reset);

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !fire) |=> lock);

    p_locked_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && lock) |=> wd_reset);

    p_halt_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_out |-> (stop_req && !lock));

endmodule

bind wdog_cascade wdog_cascade_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .stop_req (stop_req),
    .wd_reset (wd_reset),
    .halt_out (halt_out),
    .rd_data  (rd_data),
    .run      (run_w),
    .lock     (lock_w),
    .fire     (fire_w),
    .hi_uf    (hi_uf),
    .lo_cnt   (lo_cnt),
    .hi_cnt   (hi_cnt)
);

// File: tb/sim_wdog_cascade.sv
`timescale 1ns/1ps
module sim_wdog_cascade;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_req = 1'b0;
    logic [7:0] rd_data;
    logic       halt_out;
    logic       wd_reset;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_cascade #(.CNT_W(8)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .stop_req (stop_req),
        .rd_data  (rd_data),
        .halt_out (halt_out),
        .wd_reset (wd_reset)
    );

    typedef struct {
        int         due;
        bit         use_st;
        logic [7:0] rd;
        logic       rst;
        logic       halt;
        string      tag;
    } item_t;

    item_t sb[$];

    // Monitor: compares expected items at the falling edge of their cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.due < cyc) begin
                fails++;
                $display("FAIL %s: missed cycle %0d (now %0d)", it.tag, it.due, cyc);
            end else if (it.use_st) begin
                if (rd_data !== it.rd || wd_reset !== it.rst) begin
                    fails++;
                    $display("FAIL %s: rd=%h rst=%b expected rd=%h rst=%b",
                             it.tag, rd_data, wd_reset, it.rd, it.rst);
                end
            end else if (halt_out !== it.halt) begin
                fails++;
                $display("FAIL %s: halt=%b expected halt=%b", it.tag, halt_out, it.halt);
            end
        end
    end

    task automatic drive(input logic w, input logic [7:0] d, input logic t, input logic s);
        @(posedge clk);
        #1;
        wr_en = w; wr_data = d; tick = t; stop_req = s;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic exp_st(input logic [7:0] rd, input logic rst, input string tag);
        item_t it;
        it.due = cyc; it.use_st = 1'b1; it.rd = rd; it.rst = rst; it.halt = 1'b0; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_halt(input logic h, input string tag);
        item_t it;
        it.due = cyc; it.use_st = 1'b0; it.rd = 8'h00; it.rst = 1'b0; it.halt = h; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        exp_st(8'h3F, 1'b0, "R2 reset readback");

        // R1: ticks before any write do nothing
        ticks(300);
        idle();
        exp_st(8'h3F, 1'b0, "R1 dormant ignores tick");

        // R8: dormant stop request passes through, no reset
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        exp_halt(1'b1, "R8 dormant halt");
        idle();
        exp_st(8'h3F, 1'b0, "R8 dormant no reset");

        // R5: short timeout, bit 7 set
        drive(1'b1, 8'h80, 1'b0, 1'b0);
        idle();
        exp_st(8'hBF, 1'b0, "R9 readback src bit");
        ticks(4);
        idle();
        exp_st(8'hBE, 1'b0, "R5 direct count after 4 ticks");
        ticks(251);
        idle();
        exp_st(8'h80, 1'b0, "R5 one tick before timeout");
        ticks(1);
        idle();
        exp_st(8'h3F, 1'b1, "R3 R5 reset after 256 ticks");
        idle();
        exp_st(8'h3F, 1'b0, "R3 single-cycle pulse");
        ticks(600);
        idle();
        exp_st(8'h3F, 1'b0, "R1 dormant after timeout");

        // R4: cascaded timeout
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        idle();
        exp_st(8'h3F, 1'b0, "R2 write arms with all-ones");
        ticks(1023);
        idle();
        exp_st(8'h3F, 1'b0, "R4 after 1023 ticks");
        ticks(1);
        idle();
        exp_st(8'h3E, 1'b0, "R4 after 1024 ticks");
        ticks(64511);
        idle();
        exp_st(8'h00, 1'b0, "R4 one tick before timeout");
        ticks(1);
        idle();
        exp_st(8'h3F, 1'b1, "R4 reset after 65536 ticks");

        // R2/R10: kick reloads both stages, write beats tick
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        ticks(40000);
        idle();
        exp_st(8'h18, 1'b0, "R4 partial count 40000 ticks");
        drive(1'b1, 8'h00, 1'b1, 1'b0);
        idle();
        exp_st(8'h3F, 1'b0, "R10 write beats tick");
        ticks(65535);
        idle();
        exp_st(8'h00, 1'b0, "R2 low stage also reloaded");
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        idle();
        exp_st(8'h3F, 1'b0, "R2 kick before timeout");

        // R8: armed, lock clear, stop allowed
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        exp_halt(1'b1, "R8 armed unlocked halt");
        idle();
        exp_st(8'h3F, 1'b0, "R8 armed unlocked no reset");

        // R6: sticky lock, R7: locked stop resets
        drive(1'b1, 8'h40, 1'b0, 1'b0);
        idle();
        exp_st(8'h7F, 1'b0, "R6 lock set");
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        idle();
        exp_st(8'h7F, 1'b0, "R6 write 0 keeps lock");
        drive(1'b1, 8'h80, 1'b0, 1'b0);
        idle();
        exp_st(8'hFF, 1'b0, "R6 src takes written value");
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        idle();
        exp_st(8'h7F, 1'b0, "R6 src cleared lock kept");
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        exp_halt(1'b0, "R7 locked stop no halt");
        idle();
        exp_st(8'h3F, 1'b1, "R7 locked stop resets");
        idle();
        exp_st(8'h3F, 1'b0, "R3 lock cleared by reset");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule